// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, day of week, date, month, two-digit year and century. A single-cycle `tick_i` pulse, expected once per second, advances a carry chain of counters. Month lengths, February in leap years, the year wrap and the century carry are all handled inside that chain.

The host never reads the counters directly. It sees a set of holding bytes that the counters refresh on every tick. Two control bits change that. A hold bit freezes the holding bytes so that a multi-byte read is coherent. A set bit does the same and also opens the holding bytes to host writes. When the host then clears the set bit, the holding bytes are copied into the counters.

A five-byte alarm is compared against the time that each tick produces. The fields compared are month, date, hours, minutes and seconds. A full match raises a sticky flag, which is driven on `alarm_o` and is also visible in the flag byte. Reading the flag byte clears it.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the registers read as follows: flag byte 0x00, century 0x20, year 0x00, month 0x01, date 0x01, day of week 0x01, hours, minutes and seconds 0x00, control 0x00, and every alarm byte 0x00. Register addresses are: flag 0, century 1, alarm seconds/minutes/hours/date/month at 2 to 6, control 7, and seconds/minutes/hours/day/date/month/year at 8 to 14. All other addresses read 0x00.
- R2: Each `tick_i` pulse advances seconds by one in BCD. Seconds wrap 0x59 to 0x00 and carry into minutes. Minutes wrap 0x59 to 0x00 and carry into hours. Hours wrap 0x23 to 0x00. With no tick and no load, the counters hold their value.
- R3: When the hours wrap, the date advances. After day 30 of months 4, 6, 9 and 11, and after day 31 of the other months, the date returns to 0x01 and the month advances. Month 0x12 wraps to 0x01 and advances the year.
- R4: February ends on day 0x29 when the year value is divisible by 4, and on day 0x28 otherwise.
- R5: The year wraps from 0x99 to 0x00 and increments the BCD century byte. The century itself wraps from 0x99 to 0x00.
- R6: The day of week runs from 0x01 to 0x07. It advances when the hours wrap and goes from 0x07 back to 0x01.
- R7: The holding bytes take the new counter value on every tick unless control bit 6 (hold) or bit 7 (set) is 1. After hold is released they keep their stale value until the next tick.
- R8: Host writes to the time bytes and to the century byte have no effect while control bit 7 is 0.
- R9: While control bit 7 is 1, host writes land in the holding bytes and ticks do not disturb them. A control write that changes bit 7 from 1 to 0 loads all eight holding bytes into the counters, and counting continues from the loaded value.
- R10: When a tick produces a time whose month, date, hours, minutes and seconds all equal the alarm bytes, the alarm flag is set. It is reported as bit 7 of the flag byte and on `alarm_o`, and it stays set over later ticks. A mismatch in any one of the five fields keeps the flag clear.
- R11: A read strobe (`rd_i`) at address 0 returns the flag byte in that cycle and clears the flag at the clock edge, unless a new match sets it at the same edge.
- R12: The control byte and the alarm bytes read back exactly what was written. Control bits 5 to 0 are stored but have no effect on timekeeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse that advances time by one second |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; clears the alarm flag when it reads the flag byte |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The hardest state to reach from the ports is the last second of an arbitrary day: month ends, leap and non-leap Februaries, and the year and century carries. Stepping there with ticks alone would take millions of cycles. The bench instead uses the set-mode load path to place the counters at 23:59:59 on every day of several chosen years, covering a leap year, a non-leap year, year 00 and year 99. It then applies one tick and compares all eight bytes against a model of the calendar computed in integers.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF = 8;  // time fields
  localparam int NA = 5;  // alarm fields

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;
  localparam int F_CENT = 7;

  localparam int A_FLAG = 0;
  localparam int A_CENT = 1;
  localparam int A_ALM  = 2;
  localparam int A_CTRL = 7;
  localparam int A_SEC  = 8;

  localparam int CTRL_SET  = 7;
  localparam int CTRL_HOLD = 6;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] sec;
  } rtc_time_t;

  function automatic rtc_time_t rst_time(input logic [7:0] cent);
    rtc_time_t t;
    t      = '0;
    t.cent = cent;
    t.mon  = 8'h01;
    t.date = 8'h01;
    t.dow  = 8'h01;
    return t;
  endfunction

  function automatic int field_addr(input int i);
    return (i == F_CENT) ? A_CENT : A_SEC + i;
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  // divisible by 4: tens even -> ones in {0,4,8}; tens odd -> ones in {2,6}
  function automatic logic leap_bcd(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field (
  input  logic [7:0] val_i,
  input  logic       en_i,
  input  logic       at_max_i,
  input  logic [7:0] min_i,
  output logic [7:0] nxt_o
);
  import rtc_pkg::*;

  always_comb begin
    nxt_o = val_i;
    if (en_i) nxt_o = at_max_i ? min_i : bcd_inc(val_i);
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o,
  output rtc_time_t nxt_o
);
  rtc_time_t cnt_q;
  logic [NF-1:0][7:0] cur, nxt, fmax, fmin;
  logic [NF-1:0] en, at_max;
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cent;

  assign cur  = cnt_q;
  assign fmax = {8'h99, 8'h99, 8'h12, last_day(cnt_q.mon, cnt_q.yr),
                 8'h07, 8'h23, 8'h59, 8'h59};
  assign fmin = {8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // carries formed from at_max only, no path through en
  assign c_min  = tick_i & at_max[F_SEC];
  assign c_hr   = c_min  & at_max[F_MIN];
  assign c_day  = c_hr   & at_max[F_HR];
  assign c_mon  = c_day  & at_max[F_DATE];
  assign c_yr   = c_mon  & at_max[F_MON];
  assign c_cent = c_yr   & at_max[F_YR];
  assign en = {c_cent, c_yr, c_mon, c_day, c_day, c_hr, c_min, tick_i};

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign at_max[g] = (cur[g] == fmax[g]);
    rtc_bcd_field u_fld (
      .val_i   (cur[g]),
      .en_i    (en[g]),
      .at_max_i(at_max[g]),
      .min_i   (fmin[g]),
      .nxt_o   (nxt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= rst_time(RST_CENTURY);
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
  assign nxt_o = nxt;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NA-1:0][7:0] now_i,
  input  logic [NA-1:0][7:0] alm_i,
  input  logic               clr_i,
  output logic               flag_o
);
  logic flag_q, hit;

  assign hit = tick_i && (now_i == alm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import rtc_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              alarm_o
);
  rtc_time_t          cnt_q, cnt_nxt;
  logic [NF-1:0][7:0] hold_q;
  logic [NA-1:0][7:0] alm_q, alm_now;
  logic [7:0]         ctrl_q;
  logic set_mode, hold_mode, ctrl_wr, load, refresh, flag_clr, af;

  assign set_mode  = ctrl_q[CTRL_SET];
  assign hold_mode = ctrl_q[CTRL_HOLD];
  assign ctrl_wr   = wr_i && (addr_i == ADDR_W'(A_CTRL));
  assign load      = ctrl_wr && set_mode && !wdata_i[CTRL_SET];
  assign refresh   = tick_i && !set_mode && !hold_mode;
  assign flag_clr  = rd_i && (addr_i == ADDR_W'(A_FLAG));

  rtc_time_chain #(.RST_CENTURY(RST_CENTURY)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (load),
    .load_val_i(rtc_time_t'(hold_q)),
    .cnt_o     (cnt_q),
    .nxt_o     (cnt_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= rst_time(RST_CENTURY);
    end else if (refresh) begin
      hold_q <= cnt_nxt;
    end else if (wr_i && set_mode) begin
      for (int i = 0; i < NF; i++)
        if (addr_i == ADDR_W'(field_addr(i))) hold_q[i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NA; g++) begin : g_alm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          alm_q[g] <= '0;
      else if (wr_i && (addr_i == ADDR_W'(A_ALM + g)))      alm_q[g] <= wdata_i;
    end
  end

  // alarm sees the time the tick is producing
  assign alm_now = {cnt_nxt.mon, cnt_nxt.date, cnt_nxt.hrs, cnt_nxt.mins, cnt_nxt.sec};

  rtc_alarm_unit u_alarm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .now_i (alm_now),
    .alm_i (alm_q),
    .clr_i (flag_clr),
    .flag_o(af)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_FLAG)) rdata_o = {af, 7'b0};
    if (addr_i == ADDR_W'(A_CTRL)) rdata_o = ctrl_q;
    for (int i = 0; i < NA; i++)
      if (addr_i == ADDR_W'(A_ALM + i)) rdata_o = alm_q[i];
    for (int i = 0; i < NF; i++)
      if (addr_i == ADDR_W'(field_addr(i))) rdata_o = hold_q[i];
  end

  assign alarm_o = af;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              alarm_o,
  input rtc_time_t         cnt_i,
  input logic [NF*8-1:0]   hold_i,
  input logic [7:0]        ctrl_i
);
  // R2
  cnt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_i));

  // R2
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i.sec[3:0] <= 4'd9) && (cnt_i.sec <= 8'h59));

  // R3
  date_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i.date != 8'h00) && (cnt_i.date <= 8'h31));

  // R7
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[CTRL_HOLD] && !ctrl_i[CTRL_SET]) |=> $stable(hold_i));

  // R8
  wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[CTRL_SET] && !tick_i) |=> $stable(hold_i));

  // R10
  alarm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(tick_i));

  // R11
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == ADDR_W'(A_FLAG)) && !tick_i) |=> !alarm_o);
endmodule

bind bcd_clock_calendar rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .alarm_o(alarm_o),
  .cnt_i  (cnt_q),
  .hold_i (hold_q),
  .ctrl_i (ctrl_q)
);

// File: tb/tb_bcd_clock_calendar.sv
module tb_bcd_clock_calendar;
  localparam int AW = 4;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic alarm_o;

  int vec = 0, bad = 0;
  int m_cy, m_y, m_mo, m_d, m_dw, m_h, m_mi, m_s;

  bcd_clock_calendar #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .alarm_o(alarm_o)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_dw = (m_dw == 7) ? 1 : m_dw + 1;
          m_d++;
          if (m_d > dim(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo > 12) begin
              m_mo = 1; m_y++;
              if (m_y > 99) begin
                m_y = 0;
                m_cy = (m_cy == 99) ? 0 : m_cy + 1;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] d);
    @(negedge clk);
    addr_i = AW'(a);
    #1 d = rdata_o;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic tick1();
    pulse_tick();
    model_tick();
  endtask

  task automatic set_time(input int cy, input int y, input int mo, input int d,
                          input int dw, input int h, input int mi, input int s);
    wr(7, 8'h80);
    wr(1, to_bcd(cy)); wr(14, to_bcd(y)); wr(13, to_bcd(mo)); wr(12, to_bcd(d));
    wr(11, to_bcd(dw)); wr(10, to_bcd(h)); wr(9, to_bcd(mi)); wr(8, to_bcd(s));
    wr(7, 8'h00);
    m_cy = cy; m_y = y; m_mo = mo; m_d = d; m_dw = dw; m_h = h; m_mi = mi; m_s = s;
  endtask

  task automatic check_time(input string tag);
    logic [7:0] v;
    peek(8, v);  chk({tag, "/R2 sec"}, v, to_bcd(m_s));
    peek(9, v);  chk({tag, "/R2 min"}, v, to_bcd(m_mi));
    peek(10, v); chk({tag, "/R2 hour"}, v, to_bcd(m_h));
    peek(11, v); chk({tag, "/R6 dow"}, v, to_bcd(m_dw));
    peek(12, v); chk({tag, " date"}, v, to_bcd(m_d));
    peek(13, v); chk({tag, " month"}, v, to_bcd(m_mo));
    peek(14, v); chk({tag, " year"}, v, to_bcd(m_y));
    peek(1, v);  chk({tag, " century"}, v, to_bcd(m_cy));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act running exp finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int dw;
    int years[4] = '{23, 24, 0, 99};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    m_cy = 20; m_y = 0; m_mo = 1; m_d = 1; m_dw = 1; m_h = 0; m_mi = 0; m_s = 0;
    check_time("R1");
    peek(0, v); chk("R1 flag", v, 8'h00);
    peek(7, v); chk("R1 ctrl", v, 8'h00);
    for (int a = 2; a <= 6; a++) begin peek(a, v); chk("R1 alarm", v, 8'h00); end
    peek(15, v); chk("R1 unused addr", v, 8'h00);

    // R2 seconds/minutes/hours sweep across an hour boundary
    for (int i = 0; i < 3700; i++) begin
      tick1();
      peek(8, v);  chk("R2 sec", v, to_bcd(m_s));
      peek(9, v);  chk("R2 min", v, to_bcd(m_mi));
      peek(10, v); chk("R2 hour", v, to_bcd(m_h));
    end

    // R3 R4 R5 R6: last second of every day of selected years
    dw = 1;
    foreach (years[k]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        for (int d = 1; d <= dim(mo, years[k]); d++) begin
          set_time(20, years[k], mo, d, dw, 23, 59, 59);
          tick1();
          if (mo == 2) check_time("R4");
          else if (mo == 12 && d == 31 && years[k] == 99) check_time("R5");
          else check_time("R3");
          dw = (dw == 7) ? 1 : dw + 1;
        end
      end
    end
    // R5 century wrap
    set_time(99, 99, 12, 31, 7, 23, 59, 59);
    tick1();
    check_time("R5");

    // R7 hold freezes holding bytes
    set_time(20, 24, 6, 15, 3, 10, 20, 30);
    wr(7, 8'h40);
    repeat (5) tick1();
    peek(8, v); chk("R7 frozen sec", v, 8'h30);
    wr(7, 8'h00);
    peek(8, v); chk("R7 stale after release", v, 8'h30);
    tick1();
    check_time("R7");

    // R8 writes ignored outside set mode
    wr(8, 8'h45); wr(1, 8'h19); wr(12, 8'h07);
    check_time("R8");

    // R9 set mode write and load
    wr(7, 8'h80);
    wr(8, 8'h57); wr(9, 8'h59); wr(10, 8'h23); wr(12, 8'h30);
    wr(13, 8'h04); wr(14, 8'h23); wr(11, 8'h05); wr(1, 8'h20);
    repeat (3) pulse_tick();
    peek(8, v);  chk("R9 held sec", v, 8'h57);
    peek(13, v); chk("R9 held month", v, 8'h04);
    wr(7, 8'h00);
    m_s = 57; m_mi = 59; m_h = 23; m_d = 30; m_mo = 4; m_y = 23; m_dw = 5; m_cy = 20;
    repeat (3) tick1();
    check_time("R9");

    // R12 readback of control and alarm bytes
    wr(7, 8'h3F);
    peek(7, v); chk("R12 ctrl", v, 8'h3F);
    tick1();
    check_time("R12");
    wr(7, 8'h00);
    for (int a = 2; a <= 6; a++) begin
      wr(a, 8'(8'h11 * a));
      peek(a, v); chk("R12 alarm byte", v, 8'(8'h11 * a));
    end

    // R10 alarm match on leap-day rollover
    set_time(20, 24, 2, 29, 4, 23, 59, 58);
    wr(2, 8'h01); wr(3, 8'h00); wr(4, 8'h00); wr(5, 8'h01); wr(6, 8'h03);
    peek(0, v); chk("R10 flag idle", v, 8'h00);
    tick1(); chk("R10 no match 59", {7'b0, alarm_o}, 8'h00);
    tick1(); chk("R10 no match 00", {7'b0, alarm_o}, 8'h00);
    tick1(); chk("R10 match", {7'b0, alarm_o}, 8'h01);
    repeat (2) tick1();
    chk("R10 sticky", {7'b0, alarm_o}, 8'h01);
    peek(0, v); chk("R10 flag byte", v, 8'h80);

    // R11 read clears
    @(negedge clk);
    addr_i = AW'(0); rd_i = 1'b1;
    #1 v = rdata_o;
    chk("R11 read value", v, 8'h80);
    @(negedge clk);
    rd_i = 1'b0;
    chk("R11 cleared", {7'b0, alarm_o}, 8'h00);
    peek(0, v); chk("R11 flag byte cleared", v, 8'h00);

    // R10 month mismatch keeps flag clear
    set_time(20, 24, 2, 29, 4, 23, 59, 58);
    wr(6, 8'h04);
    repeat (3) tick1();
    chk("R10 month mismatch", {7'b0, alarm_o}, 8'h00);

    finish_run();
  end
endmodule